// File: doc/BRIEF.md
# Timer compare and overflow interrupt unit

An 8-bit timer with one compare register and interrupt logic for two events. The counter moves one step each clock cycle that has the count strobe high. It runs in one of two ways. In the plain mode it counts up and wraps. In the triangle mode it counts up to the top value and then back down to zero. A compare event occurs when the counter equals the compare value. An overflow event occurs on the wrap in the plain mode. In the triangle mode it occurs where the count turns upward at zero.

Each event sets a sticky flag. Software clears a flag by writing a one to its bit. Hardware clears it when the acknowledge input for that vector pulses. A request output goes high when the global enable, the event's mask bit and its flag are all set. A small register port gives access to the counter, the compare value, the mask and the flags. Bus writes take effect at the clock edge. Reads are combinational.

Top module: `tmr8_irq_unit`

## Requirements
- R1: After reset the counter, the compare value, both mask bits, both flags and both request outputs are 0. The counter direction is up.
- R2: The address selects a register: 0 is the counter, 1 the compare value, 2 the mask, 3 the flags. In the mask and flag registers, bit 7 belongs to the compare event and bit 6 to the overflow event. All other bits read 0 and ignore writes.
- R3: In plain mode (`pwm_mode`=0), each strobe adds one to the counter. A strobe at 0xFF wraps the counter to 0x00 and sets the overflow flag at the same edge.
- R4: In triangle mode (`pwm_mode`=1), the counter counts up to 0xFF, then down to 0x00, then up again, and each extreme lasts one strobe. A strobe while counting down at 0x00 sets the overflow flag. The turn at the top sets no flag.
- R5: A strobe taken while the counter equals the compare value sets the compare flag at that edge. This holds in both directions.
- R6: A counter write loads the written value and wins over a strobe in the same cycle. The first strobe after a counter write raises no compare event, even when the values are equal.
- R7: Writing the flag register clears each flag whose bit is written as 1. Bits written as 0 leave their flag unchanged.
- R8: A pulse on `ack_cmp` or `ack_ovf` clears the matching flag.
- R9: When a flag's set event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R10: Each request output is a register. It equals the AND of `gie`, the mask bit and the flag as they stood in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe |
| pwm_mode | input | 1 | 0 plain up-count, 1 up/down triangle |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| gie | input | 1 | Global interrupt enable |
| ack_cmp | input | 1 | Compare vector serviced |
| ack_ovf | input | 1 | Overflow vector serviced |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Most state errors show up on the read port at once, and a bench that reads some register every cycle catches them there. A wrong direction bit is the exception. It stays hidden until the counter reaches an extreme, so up to 255 strobes can pass before a triangle-mode count diverges. A lost suppression bit, or a wrong choice between set and clear, shows in the flag register one cycle after the event. The request outputs trail the flags by one further cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RA_COUNT = 2'd0,
    RA_CMP   = 2'd1,
    RA_MASK  = 2'd2,
    RA_FLAG  = 2'd3
  } reg_addr_e;

  // index of each event in the internal event/flag vectors
  localparam int EV_OVF = 0;
  localparam int EV_CMP = 1;
  localparam int NUM_EV = 2;
endpackage

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         pwm_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] cmp_val_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         ovf_evt_o,
  output logic         cmp_evt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;
  logic         blk_q, blk_d;
  logic         adv;

  always_comb begin
    cnt_d     = cnt_q;
    up_d      = up_q;
    blk_d     = blk_q;
    ovf_evt_o = 1'b0;
    adv       = tick_i && !ld_i;
    cmp_evt_o = adv && !blk_q && (cnt_q == cmp_val_i);
    if (ld_i) begin
      cnt_d = ld_val_i;
      blk_d = 1'b1;
    end else if (tick_i) begin
      blk_d = 1'b0;
      if (!pwm_i) begin
        cnt_d     = cnt_q + 1'b1;
        ovf_evt_o = (cnt_q == TOP);
      end else if (up_q) begin
        if (cnt_q == TOP) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == BOT) begin
          up_d      = 1'b1;
          cnt_d     = cnt_q + 1'b1;
          ovf_evt_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    if (!pwm_i) up_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      blk_q <= blk_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic en_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)               flag_d = 1'b1;
    else if (clr_i || ack_i) flag_d = 1'b0;
    irq_d = gie_i && en_i && flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr8_irq_unit.sv
module tmr8_irq_unit
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pwm_mode,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         gie,
  input  logic         ack_cmp,
  input  logic         ack_ovf,
  output logic         irq_cmp,
  output logic         irq_ovf
);
  localparam int OVF_BIT = W - 2;   // event i lives at bit OVF_BIT+i

  reg_addr_e          sel;
  logic               wr_cnt, wr_cmp, wr_msk, wr_flg;
  logic [W-1:0]       cmp_q, cmp_d;
  logic [NUM_EV-1:0]  msk_q, msk_d;
  logic [NUM_EV-1:0]  flg_q, irq_v, evt, ack_v;
  logic [W-1:0]       cnt_q;
  logic               cnt_up;
  logic               evt_ovf, evt_cmp;

  assign sel    = reg_addr_e'(bus_addr);
  assign wr_cnt = bus_wr && (sel == RA_COUNT);
  assign wr_cmp = bus_wr && (sel == RA_CMP);
  assign wr_msk = bus_wr && (sel == RA_MASK);
  assign wr_flg = bus_wr && (sel == RA_FLAG);

  always_comb begin
    cmp_d = cmp_q;
    msk_d = msk_q;
    if (wr_cmp) cmp_d = bus_wdata;
    if (wr_msk) msk_d = bus_wdata[OVF_BIT +: NUM_EV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      msk_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      msk_q <= msk_d;
    end
  end

  tmr_cnt_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .pwm_i     (pwm_mode),
    .ld_i      (wr_cnt),
    .ld_val_i  (bus_wdata),
    .cmp_val_i (cmp_q),
    .cnt_o     (cnt_q),
    .up_o      (cnt_up),
    .ovf_evt_o (evt_ovf),
    .cmp_evt_o (evt_cmp)
  );

  assign evt[EV_OVF]   = evt_ovf;
  assign evt[EV_CMP]   = evt_cmp;
  assign ack_v[EV_OVF] = ack_ovf;
  assign ack_v[EV_CMP] = ack_cmp;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt[i]),
      .clr_i  (wr_flg && bus_wdata[OVF_BIT+i]),
      .ack_i  (ack_v[i]),
      .en_i   (msk_q[i]),
      .gie_i  (gie),
      .flag_o (flg_q[i]),
      .irq_o  (irq_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RA_COUNT: bus_rdata = cnt_q;
      RA_CMP:   bus_rdata = cmp_q;
      RA_MASK:  bus_rdata[OVF_BIT +: NUM_EV] = msk_q;
      RA_FLAG:  bus_rdata[OVF_BIT +: NUM_EV] = flg_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_cmp = irq_v[EV_CMP];
  assign irq_ovf = irq_v[EV_OVF];
endmodule

// File: rtl/tmr8_irq_unit_chk.sv
module tmr8_irq_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pwm_mode,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic         gie,
  input logic         ack_cmp,
  input logic         ack_ovf,
  input logic         irq_cmp,
  input logic         irq_ovf,
  input logic [1:0]   flg,
  input logic [1:0]   msk,
  input logic         up,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic [W-1:0] cnt
);
  logic ld;
  assign ld = bus_wr && (bus_addr == 2'd0);

  // R10
  irq_cmp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp == $past(gie && msk[1] && flg[1]));

  // R10
  irq_ovf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf == $past(gie && msk[0] && flg[0]));

  // R3
  plain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwm_mode && !ld && cnt == {W{1'b1}}) |=> (cnt == '0 && flg[0]));

  // R4
  tri_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_mode && !ld && !up && cnt == '0) |=> (flg[0] && up));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(bus_wdata)));

  // R6
  load_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !cmp_evt);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !ovf_evt) |=> !flg[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> flg[1]);
endmodule

bind tmr8_irq_unit tmr8_irq_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .pwm_mode  (pwm_mode),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .gie       (gie),
  .ack_cmp   (ack_cmp),
  .ack_ovf   (ack_ovf),
  .irq_cmp   (irq_cmp),
  .irq_ovf   (irq_ovf),
  .flg       (flg_q),
  .msk       (msk_q),
  .up        (cnt_up),
  .ovf_evt   (evt_ovf),
  .cmp_evt   (evt_cmp),
  .cnt       (cnt_q)
);

// File: tb/test_tmr8_irq_unit.sv
`timescale 1ns/1ps
module test_tmr8_irq_unit;
  logic       clk, rst_n, tick, pwm_mode, bus_wr, gie, ack_cmp, ack_ovf;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_cmp, irq_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_cnt, m_cmp;
  logic       m_up, m_blk;
  logic [1:0] m_msk, m_flg, m_irq;   // [1]=compare, [0]=overflow

  tmr8_irq_unit i_tmr8_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gie(gie), .ack_cmp(ack_cmp), .ack_ovf(ack_ovf),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // R2: expected read value per address
  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return m_cmp;
      2'd2:    return {m_msk, 6'b0};
      default: return {m_flg, 6'b0};
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 8'h00; m_cmp = 8'h00; m_up = 1'b1; m_blk = 1'b0;
    m_msk = 2'b00; m_flg = 2'b00; m_irq = 2'b00;
  endtask

  // one cycle: drive at negedge, check, advance reference at posedge
  task automatic cyc(input string tag, input logic tk, input logic pm,
                     input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic g, input logic ac, input logic ao);
    logic       ld, adv, ev_c, ev_o;
    logic [7:0] n_cnt;
    logic       n_up, n_blk;
    logic [1:0] clr, ev, n_flg;
    @(negedge clk);
    tick = tk; pwm_mode = pm; bus_wr = wr; bus_addr = a; bus_wdata = d;
    gie = g; ack_cmp = ac; ack_ovf = ao;
    #1;
    chk(tag, bus_rdata, exp_read(a));
    chk("R10", {6'b0, irq_cmp, irq_ovf}, {6'b0, m_irq});
    ld   = wr && (a == 2'd0);
    adv  = tk && !ld;
    ev_c = adv && !m_blk && (m_cnt == m_cmp);
    ev_o = 1'b0;
    n_cnt = m_cnt; n_up = m_up; n_blk = m_blk;
    if (ld) begin n_cnt = d; n_blk = 1'b1; end
    else if (tk) begin
      n_blk = 1'b0;
      if (!pm) begin ev_o = (m_cnt == 8'hFF); n_cnt = m_cnt + 8'd1; end
      else if (m_up && m_cnt == 8'hFF) begin n_up = 1'b0; n_cnt = 8'hFE; end
      else if (!m_up && m_cnt == 8'h00) begin n_up = 1'b1; n_cnt = 8'h01; ev_o = 1'b1; end
      else n_cnt = m_up ? m_cnt + 8'd1 : m_cnt - 8'd1;
    end
    if (!pm) n_up = 1'b1;
    ev  = {ev_c, ev_o};
    clr = ((wr && a == 2'd3) ? d[7:6] : 2'b00) | {ac, ao};
    n_flg = ev | (m_flg & ~clr);
    @(posedge clk);
    m_irq = {2{g}} & m_msk & m_flg;
    m_flg = n_flg;
    m_cnt = n_cnt; m_up = n_up; m_blk = n_blk;
    if (wr && a == 2'd1) m_cmp = d;
    if (wr && a == 2'd2) m_msk = d[7:6];
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic pm);
    cyc(tag, 1'b0, pm, 1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wrr(input string tag, input logic [1:0] a, input logic [7:0] d, input logic pm);
    cyc(tag, 1'b0, pm, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tk(input string tag, input int n, input logic pm);
    for (int i = 0; i < n; i++) cyc(tag, 1'b1, pm, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    model_reset();
    rst_n = 1'b0; tick = 0; pwm_mode = 0; bus_wr = 0; bus_addr = 0;
    bus_wdata = 0; gie = 0; ack_cmp = 0; ack_ovf = 0;
    // R1: reset state on every address
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); bus_addr = 2'(a); #1;
      chk("R1", bus_rdata, 8'h00);
      chk("R1", {6'b0, irq_cmp, irq_ovf}, 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd("R1", 2'(a), 1'b0);

    // R2: unused bits of mask/flag read zero
    wrr("R2", 2'd2, 8'h3F, 1'b0); rd("R2", 2'd2, 1'b0);
    wrr("R2", 2'd1, 8'hA5, 1'b0); rd("R2", 2'd1, 1'b0);

    // R3: plain wrap sets overflow flag
    wrr("R3", 2'd1, 8'h10, 1'b0);
    wrr("R3", 2'd0, 8'hFE, 1'b0);
    tk("R3", 2, 1'b0); rd("R3", 2'd3, 1'b0); rd("R3", 2'd0, 1'b0);

    // R7: write-one clears overflow only, write-zero keeps
    wrr("R7", 2'd3, 8'h00, 1'b0); rd("R7", 2'd3, 1'b0);
    wrr("R7", 2'd3, 8'h40, 1'b0); rd("R7", 2'd3, 1'b0);

    // R6: load equal to compare, next strobe gives no match
    wrr("R6", 2'd1, 8'h20, 1'b0);
    wrr("R6", 2'd0, 8'h20, 1'b0);
    tk("R6", 1, 1'b0); rd("R6", 2'd3, 1'b0); rd("R6", 2'd0, 1'b0);
    // R6: load and strobe together, load wins
    cyc("R6", 1'b1, 1'b0, 1'b1, 2'd0, 8'h55, 1'b0, 1'b0, 1'b0); rd("R6", 2'd0, 1'b0);

    // R5: real match sets compare flag
    wrr("R5", 2'd0, 8'h1F, 1'b0);
    tk("R5", 2, 1'b0); rd("R5", 2'd3, 1'b0);

    // R10: enable and global enable raise the request
    wrr("R10", 2'd2, 8'hC0, 1'b0);
    cyc("R10", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc("R10", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc("R10", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    // R8: acknowledge clears compare flag, request drops after
    cyc("R8", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 1'b0);
    cyc("R8", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc("R8", 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);

    // R9: set coinciding with write-one-clear and with acknowledge
    wrr("R9", 2'd1, 8'h30, 1'b0);
    wrr("R9", 2'd0, 8'h2F, 1'b0);
    tk("R9", 1, 1'b0);
    cyc("R9", 1'b1, 1'b0, 1'b1, 2'd3, 8'hC0, 1'b0, 1'b0, 1'b0);
    rd("R9", 2'd3, 1'b0);
    wrr("R9", 2'd0, 8'h2F, 1'b0);
    tk("R9", 1, 1'b0);
    cyc("R9", 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0);
    rd("R9", 2'd3, 1'b0);

    // R4: triangle mode, full period, overflow only at bottom
    wrr("R4", 2'd3, 8'hC0, 1'b1);
    wrr("R4", 2'd0, 8'hFD, 1'b1);
    for (int i = 0; i < 270; i++) cyc("R4", 1'b1, 1'b1, 1'b0, 2'(i % 4), 8'h00, 1'b0, 1'b0, 1'b0);
    rd("R4", 2'd3, 1'b1); rd("R4", 2'd0, 1'b1);

    // random mix against the reference
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc("R2", r[0] | r[1], (i / 700) % 2 == 1, ($urandom % 8) == 0,
          2'($urandom), 8'($urandom), r[2] | r[3], ($urandom % 16) == 0,
          ($urandom % 16) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule